// File: doc/BRIEF.md
# Passive Serial Configuration Sequencer

This block is a hardware master that loads a bitstream into a programmable target device over a passive serial link. A single start pulse begins a load. The block then drives an active-low configuration request for a minimum reset pulse and confirms that the target's active-low status line shows reset. It releases the request and polls the status line at fixed intervals until the target signals that it is ready. After a settling delay it starts the serial clock.

Bitstream bytes arrive on a valid/ready byte stream, with a flag marking the last byte. Each byte is shifted out one bit per serial clock, least significant bit first unless the source marks the stream as already bit-reversed. After the last byte the block checks that the status line is still released. When the configuration-done check is enabled, it also checks that configuration-done reads high. It then sends a trailing byte of zeros, so that the target gets the extra clock edges it needs to enter user mode.

The result is reported as done, or as an error with a code. Both stay held until the next start. All microsecond timings become cycle counts through a cycles-per-microsecond parameter. Two timing profiles, default and extended, are selected per load.

Top module: `ps_cfg_seq`

## Requirements
- R1: A start accepted from idle drives `cfg_n` low for at least T_CFG_US (2 µs) worth of clock cycles, and `dclk` stays low for as long as `cfg_n` is low.
- R2: If the synchronized `stat_n` is not low at the end of the reset pulse, the load ends with `err`=1 and `err_code`=1, and `cfg_n` returns high with no serial clocks sent.
- R3: After `cfg_n` is released, `stat_n` is sampled once every 268 µs. The number of samples is ceil(max wait / 268): 6 in the default profile (`ext_profile`=0, 1506 µs) and 12 in the extended profile (`ext_profile`=1, 3000 µs). `ext_profile` is captured at start.
- R4: If `stat_n` is still low at the last allowed sample, the load ends with `err`=1 and `err_code`=2.
- R5: Once a sample sees `stat_n` high, the first rising edge of `dclk` comes no earlier than 2 µs (default profile) or 10 µs (extended profile) later.
- R6: `data0` changes only when `dclk` falls or when a byte is loaded while `dclk` is low, so it is stable at every rising edge. Each half period of `dclk` lasts DIV clock cycles.
- R7: With `pre_rev`=0 each byte is sent bit 0 first. With `pre_rev`=1 it is sent bit 7 first. `pre_rev` is captured at start. `s_tready` is high only while streaming with the serializer idle and the last byte not yet taken.
- R8: If `stat_n` is low after the last byte has been shifted, the load ends with `err_code`=3 and no trailing clocks.
- R9: With `confd_en`=1, `conf_done` low after the last byte ends the load with `err_code`=4. With `confd_en`=0, `conf_done` is ignored.
- R10: After the end checks pass, 8 further `dclk` rising edges are sent with `data0`=0, and then `done` is set.
- R11: A start while a load is in progress is ignored. `done` and `err` are never high together, and both hold until the next accepted start clears them. After reset, `cfg_n`=1, `dclk`=0, `busy`=0, `done`=0, `err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a load (accepted only from idle) |
| ext_profile | input | 1 | 1 selects the extended timing profile |
| pre_rev | input | 1 | 1 means bytes are already bit-reversed: send bit 7 first |
| confd_en | input | 1 | 1 enables the configuration-done check |
| stat_n | input | 1 | Target status, active low (low = in reset) |
| conf_done | input | 1 | Target configuration-done flag |
| s_tdata | input | 8 | Bitstream byte |
| s_tvalid | input | 1 | Byte valid |
| s_tlast | input | 1 | Marks the final byte |
| s_tready | output | 1 | Byte accepted when high together with valid |
| cfg_n | output | 1 | Configuration request, active low |
| dclk | output | 1 | Serial clock |
| data0 | output | 1 | Serial data |
| busy | output | 1 | A load is in progress |
| done | output | 1 | Load completed successfully |
| err | output | 1 | Load aborted |
| err_code | output | 3 | 1 no reset seen, 2 not ready, 3 status error, 4 done low |

## Verification
All 256 byte values are streamed in both bit orders, and each captured bit is compared with the one computed from the byte index. This tells a correct order apart from a reversed, shifted or dropped bit. The status line is released just before the last allowed poll of the extended profile and is also held low forever in each profile. From this the poll interval, the poll count per profile and the settling delay can be read off in cycle windows. Short loads exercise every end-of-load outcome: a status fault, configuration-done low with the check on and with it off, and a target that never shows reset. A start pulsed in the middle of a load shows whether it is ignored.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;

  typedef enum logic [2:0] {
    ERR_NONE      = 3'd0,
    ERR_NO_RESET  = 3'd1,
    ERR_NOT_READY = 3'd2,
    ERR_STATUS    = 3'd3,
    ERR_DONE_LOW  = 3'd4
  } err_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PULSE,
    ST_POLL,
    ST_HOLD,
    ST_STREAM,
    ST_CHECK,
    ST_TAIL
  } st_e;

  function automatic int unsigned ceil_div(input int unsigned a, input int unsigned b);
    return (a + b - 1) / b;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ps_cfg_sync.sv
module ps_cfg_sync #(
  parameter int W = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end

endmodule

// File: rtl/ps_cfg_timer.sv
module ps_cfg_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] val,
  output logic          expired
);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/ps_cfg_shift.sv
module ps_cfg_shift #(
  parameter int DIV = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] byte_in,
  input  logic       msb_first,
  output logic       busy,
  output logic       done_p,
  output logic       dclk,
  output logic       data
);

  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] HALF_LAST = DW'(DIV - 1);

  logic [7:0]    sreg;
  logic          msbf;
  logic [2:0]    bits;
  logic [DW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg   <= '0;
      msbf   <= 1'b0;
      bits   <= '0;
      cnt    <= '0;
      busy   <= 1'b0;
      done_p <= 1'b0;
      dclk   <= 1'b0;
      data   <= 1'b0;
    end else begin
      done_p <= 1'b0;
      if (!busy) begin
        if (load) begin
          sreg <= byte_in;
          msbf <= msb_first;
          data <= msb_first ? byte_in[7] : byte_in[0];
          bits <= '0;
          cnt  <= '0;
          busy <= 1'b1;
        end
      end else if (cnt == HALF_LAST) begin
        cnt <= '0;
        if (!dclk) begin
          dclk <= 1'b1;
        end else begin
          dclk <= 1'b0;
          if (bits == 3'd7) begin
            busy   <= 1'b0;
            done_p <= 1'b1;
            data   <= 1'b0;
          end else begin
            bits <= bits + 1'b1;
            if (msbf) begin
              sreg <= {sreg[6:0], 1'b0};
              data <= sreg[6];
            end else begin
              sreg <= {1'b0, sreg[7:1]};
              data <= sreg[1];
            end
          end
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_DATA_STABLE_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(dclk) |-> $stable(data)) else $error("data moved at dclk rise"); // R6

  AST_DATA_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && busy && (data != $past(data))) |-> $fell(dclk))
    else $error("data moved away from falling edge"); // R6

endmodule

// File: rtl/ps_cfg_seq.sv
module ps_cfg_seq
  import ps_cfg_pkg::*;
#(
  parameter int CYC_PER_US   = 50,
  parameter int T_CFG_US     = 2,
  parameter int T_STAT_US    = 268,
  parameter int WAIT_DEF_US  = 1506,
  parameter int WAIT_EXT_US  = 3000,
  parameter int ST2CK_DEF_US = 2,
  parameter int ST2CK_EXT_US = 10,
  parameter int DIV          = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       ext_profile,
  input  logic       pre_rev,
  input  logic       confd_en,
  input  logic       stat_n,
  input  logic       conf_done,
  input  logic [7:0] s_tdata,
  input  logic       s_tvalid,
  input  logic       s_tlast,
  output logic       s_tready,
  output logic       cfg_n,
  output logic       dclk,
  output logic       data0,
  output logic       busy,
  output logic       done,
  output logic       err,
  output logic [2:0] err_code
);

  localparam int C_CFG     = T_CFG_US * CYC_PER_US;
  localparam int C_STAT    = T_STAT_US * CYC_PER_US;
  localparam int C_ST2_DEF = ST2CK_DEF_US * CYC_PER_US;
  localparam int C_ST2_EXT = ST2CK_EXT_US * CYC_PER_US;
  localparam int NP_DEF    = ceil_div(WAIT_DEF_US, T_STAT_US);
  localparam int NP_EXT    = ceil_div(WAIT_EXT_US, T_STAT_US);
  localparam int NP_MAX    = max2(NP_DEF, NP_EXT);
  localparam int PW        = $clog2(NP_MAX + 1);
  localparam int C_MAX     = max2(max2(C_CFG, C_STAT), max2(C_ST2_DEF, C_ST2_EXT));
  localparam int TW        = $clog2(C_MAX + 1);

  st_e          st;
  logic         ext_q, rev_q, cden_q, last_q;
  logic [PW-1:0] poll_q;
  logic         done_q, err_q, cfg_n_q;
  err_e         code_q;

  logic [1:0]   sync_q;
  logic         stat_s, cd_s;
  logic         tm_load, tm_exp;
  logic [TW-1:0] tm_val;
  logic         sh_load, sh_busy, sh_done;
  logic [7:0]   sh_byte;
  logic         last_poll, end_ok;

  ps_cfg_sync #(.W(2), .RST_VAL(2'b01)) u_sync (
    .clk(clk), .rst(rst), .d({conf_done, stat_n}), .q(sync_q)
  );
  assign stat_s = sync_q[0];
  assign cd_s   = sync_q[1];

  ps_cfg_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst(rst), .load(tm_load), .val(tm_val), .expired(tm_exp)
  );

  ps_cfg_shift #(.DIV(DIV)) u_shift (
    .clk(clk), .rst(rst), .load(sh_load), .byte_in(sh_byte), .msb_first(rev_q),
    .busy(sh_busy), .done_p(sh_done), .dclk(dclk), .data(data0)
  );

  assign last_poll = ext_q ? (poll_q == PW'(NP_EXT - 1)) : (poll_q == PW'(NP_DEF - 1));
  assign end_ok    = stat_s && (!cden_q || cd_s);
  assign s_tready  = (st == ST_STREAM) && !sh_busy && !last_q;

  always_comb begin
    tm_load = 1'b0;
    tm_val  = '0;
    sh_load = 1'b0;
    sh_byte = 8'h00;
    case (st)
      ST_IDLE: if (start) begin
        tm_load = 1'b1;
        tm_val  = TW'(C_CFG - 1);
      end
      ST_PULSE: if (tm_exp && !stat_s) begin
        tm_load = 1'b1;
        tm_val  = TW'(C_STAT - 1);
      end
      ST_POLL: if (tm_exp) begin
        if (stat_s) begin
          tm_load = 1'b1;
          tm_val  = ext_q ? TW'(C_ST2_EXT - 1) : TW'(C_ST2_DEF - 1);
        end else if (!last_poll) begin
          tm_load = 1'b1;
          tm_val  = TW'(C_STAT - 1);
        end
      end
      ST_STREAM: begin
        sh_load = s_tvalid && s_tready;
        sh_byte = s_tdata;
      end
      ST_CHECK: sh_load = end_ok;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      ext_q   <= 1'b0;
      rev_q   <= 1'b0;
      cden_q  <= 1'b0;
      last_q  <= 1'b0;
      poll_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      code_q  <= ERR_NONE;
      cfg_n_q <= 1'b1;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          ext_q   <= ext_profile;
          rev_q   <= pre_rev;
          cden_q  <= confd_en;
          last_q  <= 1'b0;
          poll_q  <= '0;
          done_q  <= 1'b0;
          err_q   <= 1'b0;
          code_q  <= ERR_NONE;
          cfg_n_q <= 1'b0;
          st      <= ST_PULSE;
        end
        ST_PULSE: if (tm_exp) begin
          cfg_n_q <= 1'b1;
          if (stat_s) begin
            err_q  <= 1'b1;
            code_q <= ERR_NO_RESET;
            st     <= ST_IDLE;
          end else begin
            st <= ST_POLL;
          end
        end
        ST_POLL: if (tm_exp) begin
          if (stat_s) begin
            st <= ST_HOLD;
          end else if (last_poll) begin
            err_q  <= 1'b1;
            code_q <= ERR_NOT_READY;
            st     <= ST_IDLE;
          end else begin
            poll_q <= poll_q + 1'b1;
          end
        end
        ST_HOLD: if (tm_exp) st <= ST_STREAM;
        ST_STREAM: begin
          if (sh_load && s_tlast) last_q <= 1'b1;
          if (sh_done && last_q) st <= ST_CHECK;
        end
        ST_CHECK: begin
          if (!stat_s) begin
            err_q  <= 1'b1;
            code_q <= ERR_STATUS;
            st     <= ST_IDLE;
          end else if (cden_q && !cd_s) begin
            err_q  <= 1'b1;
            code_q <= ERR_DONE_LOW;
            st     <= ST_IDLE;
          end else begin
            st <= ST_TAIL;
          end
        end
        ST_TAIL: if (sh_done) begin
          done_q <= 1'b1;
          st     <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign cfg_n    = cfg_n_q;
  assign busy     = (st != ST_IDLE);
  assign done     = done_q;
  assign err      = err_q;
  assign err_code = code_q;

  AST_NO_CLK_IN_PULSE: assert property (@(posedge clk) disable iff (rst)
    !cfg_n |-> !dclk) else $error("serial clock during reset pulse"); // R1

  AST_ERR_HAS_CODE: assert property (@(posedge clk) disable iff (rst)
    err |-> (err_code != 3'd0)) else $error("error without code"); // R2

  AST_READY_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst)
    s_tready |-> (cfg_n && !dclk)) else $error("ready outside streaming"); // R7

  AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_TAIL) && dclk) |-> !data0) else $error("trailer bit not zero"); // R10

  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(done && err)) else $error("done and err together"); // R11

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    ((done || err) && !start) |=> ($stable(done) && $stable(err)))
    else $error("result not held"); // R11

endmodule

// File: tb/ps_cfg_seq_tb_top.sv
`timescale 1ns/1ps
module ps_cfg_seq_tb_top;

  localparam int CYC = 4;
  localparam int DIV = 2;
  localparam int TS  = 268 * CYC;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, ext_profile = 1'b0, pre_rev = 1'b0, confd_en = 1'b0;
  logic stat_n = 1'b1, conf_done = 1'b0;
  logic [7:0] s_tdata = 8'h00;
  logic s_tvalid = 1'b0, s_tlast = 1'b0;
  logic s_tready, cfg_n, dclk, data0, busy, done, err;
  logic [2:0] err_code;

  always #10 clk = ~clk;

  ps_cfg_seq #(.CYC_PER_US(CYC), .DIV(DIV)) dut_i (
    .clk(clk), .rst(rst), .start(start), .ext_profile(ext_profile),
    .pre_rev(pre_rev), .confd_en(confd_en), .stat_n(stat_n),
    .conf_done(conf_done), .s_tdata(s_tdata), .s_tvalid(s_tvalid),
    .s_tlast(s_tlast), .s_tready(s_tready), .cfg_n(cfg_n), .dclk(dclk),
    .data0(data0), .busy(busy), .done(done), .err(err), .err_code(err_code)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // target model
  int  cyc = 0, rcnt = 0, rel_delay = 0;
  bit  seen_low = 0, never_rel = 0, no_stat = 0, end_fault = 0;
  int  t_cfgdn = 0, t_cfgup = 0, t_first = 0, t_err = 0, ncap = 0, falls = 0;
  bit  caps [0:4095];

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (!cfg_n) begin
      if (!no_stat) stat_n <= 1'b0;
      rcnt <= 0;
      seen_low <= 1'b1;
    end else if (seen_low) begin
      rcnt <= rcnt + 1;
      if (!never_rel && rcnt == rel_delay) stat_n <= 1'b1;
    end
    if (end_fault && s_tvalid && s_tready && s_tlast) stat_n <= 1'b0;
  end

  always @(negedge cfg_n) begin t_cfgdn = cyc; falls++; end
  always @(posedge cfg_n) t_cfgup = cyc;
  always @(posedge err)   t_err = cyc;
  always @(posedge dclk) begin
    if (ncap == 0) t_first = cyc;
    if (ncap < 4096) caps[ncap] = data0;
    ncap++;
  end

  function automatic logic [7:0] pat(input int i);
    return 8'(i) ^ 8'h5A;
  endfunction

  task automatic begin_load(input bit ext, input bit rev, input bit cden, input bit cdv);
    @(negedge clk);
    ncap = 0; falls = 0; seen_low = 0;
    ext_profile = ext; pre_rev = rev; confd_en = cden; conf_done = cdv;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0 && err == 1'b0, "R11 start clears result", int'(done) + int'(err), 0);
    ext_profile = ~ext; pre_rev = ~rev;
  endtask

  task automatic send(input int n);
    for (int i = 0; i < n; i++) begin
      s_tdata = pat(i); s_tvalid = 1'b1; s_tlast = (i == n - 1);
      while (!s_tready) @(negedge clk);
      @(negedge clk);
    end
    s_tvalid = 1'b0; s_tlast = 1'b0;
  endtask

  task automatic wait_end;
    while (!(done || err)) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_bits(input string req, input int n, input bit rev);
    int bad = 0, first = -1;
    for (int j = 0; j < 8 * n; j++) begin
      logic [7:0] b;
      logic e;
      b = pat(j / 8);
      e = rev ? b[7 - (j % 8)] : b[j % 8];
      if (caps[j] !== e) begin
        bad++;
        if (first < 0) first = j;
      end
    end
    chk(bad == 0, req, bad, 0);
    if (bad != 0) $display("  first mismatching bit index %0d", first);
  endtask

  task automatic check_tail(input int n);
    int ones = 0;
    for (int j = 8 * n; j < 8 * n + 8; j++) ones += int'(caps[j]);
    chk(ones == 0, "R10 trailer bits zero", ones, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cfg_n == 1 && dclk == 0 && busy == 0, "R11 reset outputs",
        {29'd0, cfg_n, dclk, busy}, 4);
    chk(done == 0 && err == 0 && s_tready == 0, "R11 reset result",
        int'(done) + int'(err) + int'(s_tready), 0);

    // S1: default profile, LSB first, all byte values, start pulsed mid-load
    never_rel = 0; no_stat = 0; end_fault = 0; rel_delay = 400;
    begin_load(1'b0, 1'b0, 1'b1, 1'b1);
    repeat (100) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    send(256);
    wait_end();
    chk(done == 1 && err == 0, "R10 default load done", int'(done), 1);
    chk(t_cfgup - t_cfgdn >= 2 * CYC && t_cfgup - t_cfgdn <= 2 * CYC + 2,
        "R1 reset pulse length", t_cfgup - t_cfgdn, 2 * CYC);
    chk(t_first - t_cfgup >= TS + 2 * CYC && t_first - t_cfgup <= TS + 2 * CYC + DIV + 4,
        "R5 default first clock", t_first - t_cfgup, TS + 2 * CYC + DIV + 1);
    chk(ncap == 8 * 257, "R10 default edge count", ncap, 8 * 257);
    check_bits("R7 LSB-first bit order", 256, 1'b0);
    check_tail(256);
    chk(falls == 1, "R11 start ignored while busy", falls, 1);
    repeat (50) @(negedge clk);
    chk(done == 1 && err == 0, "R11 done held", int'(done), 1);

    // S2: extended profile, already reversed, release just before last poll
    rel_delay = 11 * TS + 400;
    begin_load(1'b1, 1'b1, 1'b1, 1'b1);
    send(256);
    wait_end();
    chk(done == 1 && err == 0, "R3 extended late release done", int'(err_code), 0);
    chk(t_first - t_cfgup >= 12 * TS + 10 * CYC && t_first - t_cfgup <= 12 * TS + 10 * CYC + DIV + 4,
        "R5 extended first clock", t_first - t_cfgup, 12 * TS + 10 * CYC + DIV + 1);
    check_bits("R7 pre-reversed bit order", 256, 1'b1);
    check_tail(256);

    // S3: default profile, never ready
    never_rel = 1;
    begin_load(1'b0, 1'b0, 1'b1, 1'b1);
    wait_end();
    chk(err == 1 && err_code == 3'd2, "R4 default not ready code", int'(err_code), 2);
    chk(t_err - t_cfgup >= 6 * TS - 1 && t_err - t_cfgup <= 6 * TS + 3,
        "R3 default poll window", t_err - t_cfgup, 6 * TS);
    chk(ncap == 0, "R4 no clocks when not ready", ncap, 0);

    // S4: extended profile, never ready
    begin_load(1'b1, 1'b0, 1'b1, 1'b1);
    wait_end();
    chk(err == 1 && err_code == 3'd2, "R4 extended not ready code", int'(err_code), 2);
    chk(t_err - t_cfgup >= 12 * TS - 1 && t_err - t_cfgup <= 12 * TS + 3,
        "R3 extended poll window", t_err - t_cfgup, 12 * TS);
    never_rel = 0;
    rel_delay = 400;

    // S5: target never shows reset
    no_stat = 1; stat_n = 1'b1;
    begin_load(1'b0, 1'b0, 1'b1, 1'b1);
    wait_end();
    chk(err == 1 && err_code == 3'd1, "R2 no reset code", int'(err_code), 1);
    chk(cfg_n == 1 && ncap == 0, "R2 released without clocks", ncap, 0);
    no_stat = 0;

    // S6: status fault at end of stream
    end_fault = 1;
    begin_load(1'b0, 1'b0, 1'b1, 1'b1);
    send(4);
    wait_end();
    chk(err == 1 && err_code == 3'd3, "R8 status error code", int'(err_code), 3);
    chk(ncap == 32, "R8 no trailer clocks", ncap, 32);
    check_bits("R7 short stream bits", 4, 1'b0);
    end_fault = 0;

    // S7: conf_done low with check enabled
    begin_load(1'b0, 1'b1, 1'b1, 1'b0);
    send(4);
    wait_end();
    chk(err == 1 && err_code == 3'd4, "R9 done low code", int'(err_code), 4);
    chk(ncap == 32, "R9 no trailer on done low", ncap, 32);

    // S8: conf_done low with check disabled
    begin_load(1'b0, 1'b1, 1'b0, 1'b0);
    send(4);
    wait_end();
    chk(done == 1 && err == 0, "R9 done ignored when disabled", int'(err_code), 0);
    chk(ncap == 40, "R10 short trailer count", ncap, 40);
    check_bits("R7 short reversed bits", 4, 1'b1);
    check_tail(4);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", fails, checks);
      $finish;
    end
  end

endmodule